// File: doc/BRIEF.md
# Saturating Wiper Position Counter

This block holds the volatile position of a 64-tap digital potentiometer wiper. The position is a 6-bit binary code in which 00h ties the wiper to the low end of the resistor string and 3Fh ties it to the high end. The code is also presented as a registered one-hot vector that enables exactly one tap switch. The command front end drives three kinds of update. A direct load carries host data. A transfer carries the contents of a selected data register. Single-step pulses move the wiper up or down one tap while an increment/decrement command is open.

While reset is asserted, the counter copies the recall value, which is the content of data register zero, on every clock edge. When reset is released, it keeps that value until a command changes it. Stepping saturates at both ends and never wraps. When two sources arrive together, a fixed priority picks the winner. The write-protect input of the surrounding device does not reach this register.

Top module: `wiper_position_counter`

## Requirements
- R1: While rst_n is low, each rising clock edge loads wiper_pos with recall_data. After release the position holds that value, and later changes on recall_data have no effect.
- R2: host_load_en high at a rising edge makes wiper_pos equal to host_load_data after that edge.
- R3: xfer_en high with host_load_en low at a rising edge makes wiper_pos equal to xfer_data after that edge.
- R4: When host_load_en and xfer_en are both high, host_load_data wins.
- R5: With step_mode high, step_pulse high and step_up high, and no load strobe, the position rises by one after the edge.
- R6: With step_mode high, step_pulse high and step_up low, and no load strobe, the position falls by one after the edge.
- R7: A step up at 3Fh leaves 3Fh, and a step down at 00h leaves 00h. The position never wraps.
- R8: step_pulse has no effect while step_mode is low.
- R9: Either load strobe takes priority over a step pulse in the same cycle.
- R10: tap_sel has exactly one bit set, at index wiper_pos. Code 00h sets bit 0, which is the low terminal, and code 3Fh sets bit 63, which is the high terminal. tap_sel updates at the same edge as wiper_pos.
- R11: With no strobe and no step, wiper_pos and tap_sel hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; recalls the stored position |
| recall_data | input | 6 | Contents of data register zero |
| host_load_en | input | 1 | Direct load strobe from the host |
| host_load_data | input | 6 | Direct load value |
| xfer_en | input | 1 | Transfer strobe from a data register |
| xfer_data | input | 6 | Selected data register value |
| step_mode | input | 1 | Increment/decrement command open |
| step_pulse | input | 1 | One step request |
| step_up | input | 1 | 1 = toward high end, 0 = toward low end |
| wiper_pos | output | 6 | Binary wiper position |
| tap_sel | output | 64 | One-hot tap switch enables |

## Verification
Every result appears exactly one rising edge after the stimulus that causes it. This covers loads, transfers, steps and the reset recall, and both wiper_pos and tap_sel change on that same edge. The bench applies each input set just after a falling edge and lets one rising edge pass. It then reads both outputs at the next falling edge, half a period after the update and well clear of the next update. Reset checks read the outputs in the same way, after one edge with rst_n low.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Which source commits the next wiper position.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_HOST = 2'd1,
    SRC_XFER = 2'd2,
    SRC_STEP = 2'd3
  } wiper_src_e;

endpackage

// File: rtl/wiper_next_sel.sv
module wiper_next_sel
  import wiper_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic [POS_W-1:0] cur_pos,
  input  logic             host_load_en,
  input  logic [POS_W-1:0] host_load_data,
  input  logic             xfer_en,
  input  logic [POS_W-1:0] xfer_data,
  input  logic             step_mode,
  input  logic             step_pulse,
  input  logic             step_up,
  output logic [POS_W-1:0] next_pos,
  output logic             at_top,
  output logic             at_bottom
);

  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  wiper_src_e src;

  // One saturating step; the end codes are absorbing.
  function automatic logic [POS_W-1:0] sat_step(input logic [POS_W-1:0] p,
                                                input logic up);
    if (up)  return (p == POS_MAX) ? p : p + POS_W'(1);
    else     return (p == POS_MIN) ? p : p - POS_W'(1);
  endfunction

  assign at_top    = (cur_pos == POS_MAX);
  assign at_bottom = (cur_pos == POS_MIN);

  // Priority: host load, then transfer, then step, else hold.
  always_comb begin
    if (host_load_en)                  src = SRC_HOST;
    else if (xfer_en)                  src = SRC_XFER;
    else if (step_mode && step_pulse)  src = SRC_STEP;
    else                               src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_HOST: next_pos = host_load_data;
      SRC_XFER: next_pos = xfer_data;
      SRC_STEP: next_pos = sat_step(cur_pos, step_up);
      default:  next_pos = cur_pos;
    endcase
  end

  // R7: the selected value never leaves the range across an end.
  always_comb begin
    if (src == SRC_STEP && step_up && at_top)
      assert_sat_top_R7: assert (next_pos == POS_MAX);
    if (src == SRC_STEP && !step_up && at_bottom)
      assert_sat_bottom_R7: assert (next_pos == POS_MIN);
  end

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int POS_W = 6,
  parameter int TAPS  = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] commit_pos,
  output logic [TAPS-1:0]  tap_sel
);

  logic [TAPS-1:0] tap_q;

  // One flop per switch; each compares the committed code with its index.
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      tap_q[t] <= (commit_pos == POS_W'(t));
    end
  end

  assign tap_sel = tap_q;

  // R10: never two switches on, never none.
  assert_one_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_q) == 1);

endmodule

// File: rtl/wiper_position_counter.sv
module wiper_position_counter #(
  parameter int POS_W = 6,
  parameter int TAPS  = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] recall_data,
  input  logic             host_load_en,
  input  logic [POS_W-1:0] host_load_data,
  input  logic             xfer_en,
  input  logic [POS_W-1:0] xfer_data,
  input  logic             step_mode,
  input  logic             step_pulse,
  input  logic             step_up,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_sel
);

  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] next_pos;
  logic [POS_W-1:0] commit_pos;
  logic             at_top;
  logic             at_bottom;

  // Named events for the assertions.
  logic any_load;
  logic step_req;
  assign any_load = host_load_en | xfer_en;
  assign step_req = step_mode & step_pulse;

  wiper_next_sel #(.POS_W(POS_W)) i_next (
    .cur_pos        (pos_q),
    .host_load_en   (host_load_en),
    .host_load_data (host_load_data),
    .xfer_en        (xfer_en),
    .xfer_data      (xfer_data),
    .step_mode      (step_mode),
    .step_pulse     (step_pulse),
    .step_up        (step_up),
    .next_pos       (next_pos),
    .at_top         (at_top),
    .at_bottom      (at_bottom)
  );

  // Reset recalls the stored position; otherwise take the selected value.
  assign commit_pos = rst_n ? next_pos : recall_data;

  always_ff @(posedge clk) begin
    pos_q <= commit_pos;
  end

  wiper_tap_decode #(.POS_W(POS_W), .TAPS(TAPS)) i_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_pos (commit_pos),
    .tap_sel    (tap_sel)
  );

  assign wiper_pos = pos_q;

  // R2 and R4: host data wins over everything.
  assert_host_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_load_en |=> wiper_pos == $past(host_load_data));

  // R3 and R9: transfer wins over a step.
  assert_xfer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !host_load_en) |=> wiper_pos == $past(xfer_data));

  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && step_up && !any_load && !at_top)
      |=> wiper_pos == $past(wiper_pos) + POS_W'(1));

  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_up && !any_load && !at_bottom)
      |=> wiper_pos == $past(wiper_pos) - POS_W'(1));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !any_load && ((step_up && at_top) || (!step_up && at_bottom)))
      |=> $stable(wiper_pos));

  // R8 and R11: without a load, a gated step leaves the position alone.
  assert_step_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_mode && !any_load) |=> $stable(wiper_pos));

  // R10: the decoder and the counter agree.
  assert_tap_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[wiper_pos] == 1'b1);

  assert_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_pos == POS_MIN) |-> tap_sel[0]);

endmodule

// File: tb/test_wiper_position_counter.sv
module test_wiper_position_counter;

  localparam int POS_W = 6;
  localparam int TAPS  = 1 << POS_W;
  localparam int NVEC  = 13;

  typedef struct packed {
    logic             hl;
    logic [POS_W-1:0] hd;
    logic             xe;
    logic [POS_W-1:0] xd;
    logic             mode;
    logic             pulse;
    logic             up;
    logic [POS_W-1:0] exp_pos;
    logic [3:0]       req;
  } vec_t;

  // Starting position is 15h from the reset recall.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'h3E, 1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 6'h3E, 4'd2},  // R2 host load
    '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b1, 1'b1, 6'h3F, 4'd5},  // R5 step up
    '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b1, 1'b1, 6'h3F, 4'd7},  // R7 top saturates
    '{1'b0, 6'h00, 1'b1, 6'h01, 1'b0, 1'b0, 1'b0, 6'h01, 4'd3},  // R3 transfer
    '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b1, 1'b0, 6'h00, 4'd6},  // R6 step down
    '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b1, 1'b0, 6'h00, 4'd7},  // R7 bottom saturates
    '{1'b0, 6'h00, 1'b0, 6'h00, 1'b0, 1'b1, 1'b1, 6'h00, 4'd8},  // R8 gated pulse
    '{1'b1, 6'h10, 1'b1, 6'h20, 1'b0, 1'b0, 1'b0, 6'h10, 4'd4},  // R4 host over transfer
    '{1'b1, 6'h05, 1'b0, 6'h00, 1'b1, 1'b1, 1'b1, 6'h05, 4'd9},  // R9 host over step
    '{1'b0, 6'h00, 1'b1, 6'h30, 1'b1, 1'b1, 1'b0, 6'h30, 4'd9},  // R9 transfer over step
    '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 1'b1, 6'h30, 4'd11}, // R11 idle hold
    '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b1, 1'b1, 6'h31, 4'd5},  // R5 step up mid-range
    '{1'b1, 6'h00, 1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 6'h00, 4'd10}  // R10 low terminal
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [POS_W-1:0] recall_data = 6'h15;
  logic             host_load_en = 1'b0;
  logic [POS_W-1:0] host_load_data = '0;
  logic             xfer_en = 1'b0;
  logic [POS_W-1:0] xfer_data = '0;
  logic             step_mode = 1'b0;
  logic             step_pulse = 1'b0;
  logic             step_up = 1'b0;
  logic [POS_W-1:0] wiper_pos;
  logic [TAPS-1:0]  tap_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wiper_position_counter #(.POS_W(POS_W), .TAPS(TAPS)) i_wiper_position_counter (
    .clk            (clk),
    .rst_n          (rst_n),
    .recall_data    (recall_data),
    .host_load_en   (host_load_en),
    .host_load_data (host_load_data),
    .xfer_en        (xfer_en),
    .xfer_data      (xfer_data),
    .step_mode      (step_mode),
    .step_pulse     (step_pulse),
    .step_up        (step_up),
    .wiper_pos      (wiper_pos),
    .tap_sel        (tap_sel)
  );

  task automatic check(input logic [POS_W-1:0] exp, input int req);
    logic [TAPS-1:0] exp_tap;
    exp_tap = '0;
    exp_tap[exp] = 1'b1;
    checks++;
    if (wiper_pos !== exp) begin
      fails++;
      $display("FAIL R%0d: wiper_pos actual %h expected %h", req, wiper_pos, exp);
    end
    checks++;
    if (tap_sel !== exp_tap) begin
      fails++;
      $display("FAIL R%0d: tap_sel actual %h expected %h", req, tap_sel, exp_tap);
    end
  endtask

  // Drive after a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    host_load_en = 1'b0;
    xfer_en      = 1'b0;
    step_mode    = 1'b0;
    step_pulse   = 1'b0;
    step_up      = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cycle();
    cycle();
    // R1: recall during reset
    check(6'h15, 1);
    rst_n = 1'b1;
    cycle();
    check(6'h15, 1);
    // R1: recall source ignored outside reset
    recall_data = 6'h2A;
    cycle();
    check(6'h15, 1);

    for (int i = 0; i < NVEC; i++) begin
      host_load_en   = VECS[i].hl;
      host_load_data = VECS[i].hd;
      xfer_en        = VECS[i].xe;
      xfer_data      = VECS[i].xd;
      step_mode      = VECS[i].mode;
      step_pulse     = VECS[i].pulse;
      step_up        = VECS[i].up;
      cycle();
      check(VECS[i].exp_pos, int'(VECS[i].req));
    end
    idle_inputs();

    // R10: high terminal via a fresh reset recall, then R11 hold after release
    recall_data = 6'h3F;
    rst_n = 1'b0;
    cycle();
    check(6'h3F, 10);
    rst_n = 1'b1;
    recall_data = 6'h00;
    cycle();
    check(6'h3F, 11);

    // R6 then R7: walk down to the bottom in mode
    step_mode = 1'b1;
    host_load_en = 1'b1; host_load_data = 6'h02;
    cycle();
    host_load_en = 1'b0;
    step_pulse = 1'b1; step_up = 1'b0;
    cycle();
    check(6'h01, 6);
    cycle();
    check(6'h00, 6);
    cycle();
    check(6'h00, 7);
    idle_inputs();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule